// File: doc/BRIEF.md
# Video Memory Address Remap and Beam-Timed Access Gate

This block sits between a processor's memory-mapped port and a byte-wide video memory. Each access carries a 16-bit word address. The block reorders the address through one of four bit-rotation schemes, so that tile-shaped data can be stored with a linear walk. It then doubles the result into a byte address.

The block also decides from the beam position whether an access is allowed. The inputs that set this are the vertical and horizontal counters and the flags for display off, tall picture, frame standard, interlace and field. While the picture is being drawn, reads return zero and writes are dropped. The rules are exact at a few single dots near the frame edges. At one dot, the byte held on the processor bus is stored in place of the write data.

The memory is a simple behavioural array inside the block. Read results come back one clock after the read strobe. A small two-state machine marks which cycle carries the read result. In `ST_IDLE` no result is pending. `ST_IDLE -> ST_RESP` is taken on a read strobe that has no write strobe with it. `ST_RESP -> ST_RESP` is taken on a further such read strobe. `ST_RESP -> ST_IDLE` is taken otherwise. `ST_IDLE -> ST_IDLE` is taken when there is no such read.

Top module: `vram_gate`

## Requirements
- R1: With `map_sel`=0, `mem_addr` equals `{word_addr, 1'b0}`. It follows the inputs combinationally, in the same cycle.
- R2: With `map_sel`=1, the word address is rebuilt as `{a[15:8], a[4:0], a[7:5]}` before it is doubled onto `mem_addr`.
- R3: With `map_sel`=2 the word is rebuilt as `{a[15:9], a[5:0], a[8:6]}`. With `map_sel`=3 it is rebuilt as `{a[15:10], a[6:0], a[9:7]}`. In both cases the result is then doubled.
- R4: While `blank_force`=1, every read returns the stored byte and every write stores `wr_data`, whatever the beam position.
- R5: Let `last` be 224 when `tall_mode`=0 and 239 when `tall_mode`=1. With the display on, a read while `vpos` < `last` returns 0. A read on line `last` returns the stored byte only when `hpos`=1362, and returns 0 at every other dot. A read on any later line returns the stored byte, except as R6 says.
- R6: Let the end line be 261 when `pal_mode`=0 and 311 when `pal_mode`=1, plus 1 when `interlace_on`=1 and `odd_field`=0. With the display on, a read on the end line at `hpos`=1362 returns 0.
- R7: With the display on and `vpos`=0, a write with `hpos` of 4 or less stores `wr_data`. A write at `hpos`=6 stores `hold_byte`. A write at any other dot is dropped, which means `mem_we` stays 0.
- R8: With the display on, writes on lines 1 through `last` are dropped. On line `last`+1, a write with `hpos` of 4 or less is dropped and any other write stores `wr_data`. A write on any later line stores `wr_data`. A dropped write leaves the memory unchanged.
- R9: A read strobe without a write strobe raises `rd_valid` in the following cycle only. `rd_data` holds the result from then until the next read. After reset, `rd_valid`=0 and `rd_data`=0.
- R10: When `rd_stb` and `wr_stb` are high together, only the write takes place, and `rd_valid` stays 0 in the next cycle.
- R11: `mem_we` is high only in a cycle where `wr_stb` is high, so one strobe stores at most one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| word_addr | input | 16 | Word address from the processor |
| map_sel | input | 2 | Selects the address rotation scheme (0 to 3) |
| wr_data | input | 8 | Byte to write |
| hold_byte | input | 8 | Byte last seen on the processor bus |
| vpos | input | 9 | Current beam line |
| hpos | input | 11 | Current beam dot |
| blank_force | input | 1 | 1 when the display is forced off |
| tall_mode | input | 1 | 1 for the 239-line picture |
| pal_mode | input | 1 | 1 for the 625-line frame standard |
| interlace_on | input | 1 | 1 when interlace is enabled |
| odd_field | input | 1 | Current field flag |
| mem_addr | output | 17 | Byte address sent to the memory |
| mem_we | output | 1 | Memory write enable for this cycle |
| mem_wdata | output | 8 | Byte written to the memory |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | High in the cycle after an accepted read |

## Verification
The assertions assume that the strobes are held low during reset. They also assume that the beam inputs and the flags are stable for the whole cycle in which a strobe is high, because the gating decision is taken from that cycle's values alone. The bench changes every input only on the falling clock edge. It raises each strobe for exactly one cycle, so each access sees a single consistent beam position.

// File: rtl/vram_gate_pkg.sv
package vram_gate_pkg;

    // Source of the byte that a write commits
    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_DATA = 2'd1,
        WSRC_HOLD = 2'd2
    } wsrc_e;

    // Read response sequencing
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/vram_addr_remap.sv
module vram_addr_remap #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_addr,
    input  logic [1:0]        map_sel,
    output logic [WORD_W:0]   byte_addr
);
    localparam int NMODES = 4;

    logic [WORD_W-1:0] cand [NMODES];

    assign cand[0] = word_addr;

    // Mode m rotates the low (m+7) bits: the low (m+4) bits move up by 3
    // and the three bits above them drop to the bottom.
    for (genvar m = 1; m < NMODES; m++) begin : g_rot
        localparam int N = m + 4;
        localparam int B = N + 3;
        assign cand[m] = {word_addr[WORD_W-1:B], word_addr[N-1:0], word_addr[B-1:N]};
    end

    assign byte_addr = {cand[map_sel], 1'b0};
endmodule

// File: rtl/vram_beam_policy.sv
module vram_beam_policy
    import vram_gate_pkg::*;
#(
    parameter int V_W           = 9,
    parameter int H_W           = 11,
    parameter int LAST_STD      = 224,
    parameter int LAST_TALL     = 239,
    parameter int FRAME_LINES_A = 525,
    parameter int FRAME_LINES_B = 625,
    parameter int EDGE_DOT      = 1362,
    parameter int EARLY_DOT_MAX = 4,
    parameter int HOLD_DOT      = 6
) (
    input  logic [V_W-1:0] vpos,
    input  logic [H_W-1:0] hpos,
    input  logic           blank_force,
    input  logic           tall_mode,
    input  logic           pal_mode,
    input  logic           interlace_on,
    input  logic           odd_field,
    output logic           rd_allow,
    output wsrc_e          wsrc
);
    localparam logic [V_W-1:0] L_STD   = V_W'(LAST_STD);
    localparam logic [V_W-1:0] L_TALL  = V_W'(LAST_TALL);
    localparam logic [V_W-1:0] VEND_A  = V_W'(FRAME_LINES_A / 2 - 1);
    localparam logic [V_W-1:0] VEND_B  = V_W'(FRAME_LINES_B / 2 - 1);
    localparam logic [H_W-1:0] H_EDGE  = H_W'(EDGE_DOT);
    localparam logic [H_W-1:0] H_EARLY = H_W'(EARLY_DOT_MAX);
    localparam logic [H_W-1:0] H_HOLD  = H_W'(HOLD_DOT);

    logic [V_W-1:0] last_line;
    logic [V_W-1:0] first_blank;
    logic [V_W-1:0] end_line;
    logic           at_edge;
    logic           early;

    assign last_line   = tall_mode ? L_TALL : L_STD;
    assign first_blank = last_line + 1'b1;
    assign end_line    = (pal_mode ? VEND_B : VEND_A) + V_W'(interlace_on && !odd_field);
    assign at_edge     = (hpos == H_EDGE);
    assign early       = (hpos <= H_EARLY);

    always_comb begin
        if (blank_force)                       rd_allow = 1'b1;
        else if (vpos == end_line && at_edge)  rd_allow = 1'b0;
        else if (vpos < last_line)             rd_allow = 1'b0;
        else if (vpos == last_line)            rd_allow = at_edge;
        else                                   rd_allow = 1'b1;
    end

    always_comb begin
        if (blank_force) begin
            wsrc = WSRC_DATA;
        end else if (vpos == '0) begin
            if (early)                wsrc = WSRC_DATA;
            else if (hpos == H_HOLD)  wsrc = WSRC_HOLD;
            else                      wsrc = WSRC_NONE;
        end else if (vpos < first_blank) begin
            wsrc = WSRC_NONE;
        end else if (vpos == first_blank) begin
            wsrc = early ? WSRC_NONE : WSRC_DATA;
        end else begin
            wsrc = WSRC_DATA;
        end
    end
endmodule

// File: rtl/vram_store.sv
module vram_store #(
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/vram_gate.sv
module vram_gate
    import vram_gate_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 10,
    parameter int V_W    = 9,
    parameter int H_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] word_addr,
    input  logic [1:0]        map_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] hold_byte,
    input  logic [V_W-1:0]    vpos,
    input  logic [H_W-1:0]    hpos,
    input  logic              blank_force,
    input  logic              tall_mode,
    input  logic              pal_mode,
    input  logic              interlace_on,
    input  logic              odd_field,
    output logic [WORD_W:0]   mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              rd_allow;
    wsrc_e             wsrc;
    logic [DATA_W-1:0] ram_q;
    logic              rd_go;
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] rd_data_q;

    vram_addr_remap #(.WORD_W(WORD_W)) u_remap (
        .word_addr (word_addr),
        .map_sel   (map_sel),
        .byte_addr (mem_addr)
    );

    vram_beam_policy #(.V_W(V_W), .H_W(H_W)) u_policy (
        .vpos         (vpos),
        .hpos         (hpos),
        .blank_force  (blank_force),
        .tall_mode    (tall_mode),
        .pal_mode     (pal_mode),
        .interlace_on (interlace_on),
        .odd_field    (odd_field),
        .rd_allow     (rd_allow),
        .wsrc         (wsrc)
    );

    assign mem_we    = wr_stb && (wsrc != WSRC_NONE);
    assign mem_wdata = (wsrc == WSRC_HOLD) ? hold_byte : wr_data;

    vram_store #(.AW(RAM_AW), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr[RAM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (ram_q)
    );

    // A write strobe takes the cycle; a read alongside it is discarded.
    assign rd_go = rd_stb && !wr_stb;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Read result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data_q <= '0;
        else if (rd_go) rd_data_q <= rd_allow ? ram_q : '0;
    end

    // Outputs
    always_comb begin
        rd_valid = (state_q == ST_RESP);
        rd_data  = rd_data_q;
    end
endmodule

// File: rtl/vram_gate_chk.sv
module vram_gate_chk #(
    parameter int DATA_W = 8,
    parameter int V_W    = 9,
    parameter int H_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] hold_byte,
    input logic [V_W-1:0]    vpos,
    input logic [H_W-1:0]    hpos,
    input logic              blank_force,
    input logic              tall_mode,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    logic [V_W-1:0] last_line;
    assign last_line = tall_mode ? V_W'(239) : V_W'(224);

    assert_we_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_stb);

    assert_read_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> rd_valid);

    assert_valid_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb && !wr_stb));

    assert_forced_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && blank_force) |-> (mem_we && mem_wdata == wr_data));

    assert_active_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !blank_force && vpos != '0 && vpos <= last_line) |-> !mem_we);

    assert_hold_dot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !blank_force && vpos == '0 && hpos == H_W'(6))
        |-> (mem_we && mem_wdata == hold_byte));

    assert_active_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !blank_force && vpos < last_line) |=> (rd_data == '0));
endmodule

bind vram_gate vram_gate_chk #(.DATA_W(DATA_W), .V_W(V_W), .H_W(H_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .hold_byte   (hold_byte),
    .vpos        (vpos),
    .hpos        (hpos),
    .blank_force (blank_force),
    .tall_mode   (tall_mode),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
);

// File: tb/vram_gate_test.sv
`timescale 1ns/1ps
module vram_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0;
    logic [15:0] word_addr = '0;
    logic [1:0]  map_sel = '0;
    logic [7:0]  wr_data = '0, hold_byte = '0;
    logic [8:0]  vpos = '0;
    logic [10:0] hpos = '0;
    logic        blank_force = 1'b0, tall_mode = 1'b0, pal_mode = 1'b0;
    logic        interlace_on = 1'b0, odd_field = 1'b0;
    logic [16:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vram_gate uut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .word_addr(word_addr), .map_sel(map_sel), .wr_data(wr_data),
        .hold_byte(hold_byte), .vpos(vpos), .hpos(hpos),
        .blank_force(blank_force), .tall_mode(tall_mode), .pal_mode(pal_mode),
        .interlace_on(interlace_on), .odd_field(odd_field),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // kind: 0 read, 1 write. expect: 0 zero/drop, 1 data, 2 hold byte
    typedef struct packed {
        logic        kind;
        logic [8:0]  v;
        logic [10:0] h;
        logic        tall;
        logic        pal;
        logic        il;
        logic        fld;
        logic [1:0]  expect_k;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 9'd0,   11'd0,    1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd100, 11'd500,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd224, 11'd1361, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd224, 11'd1362, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b0, 9'd225, 11'd0,    1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b0, 9'd239, 11'd1362, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b0, 9'd239, 11'd100,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd224, 11'd1362, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd261, 11'd1362, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd261, 11'd1361, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b0, 9'd262, 11'd1362, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
        '{1'b0, 9'd261, 11'd1362, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{1'b0, 9'd261, 11'd1362, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},
        '{1'b0, 9'd311, 11'd1362, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        '{1'b0, 9'd261, 11'd1362, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
        '{1'b0, 9'd312, 11'd1362, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{1'b1, 9'd0,   11'd0,    1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b1, 9'd0,   11'd4,    1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b1, 9'd0,   11'd5,    1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd0,   11'd6,    1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
        '{1'b1, 9'd0,   11'd7,    1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd1,   11'd10,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd224, 11'd800,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd225, 11'd4,    1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd225, 11'd5,    1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b1, 9'd240, 11'd4,    1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd240, 11'd5,    1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        '{1'b1, 9'd239, 11'd500,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd225, 11'd3,    1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{1'b1, 9'd300, 11'd0,    1'b0, 1'b0, 1'b0, 1'b0, 2'd1}
    };

    localparam int NA = 6;
    localparam logic [15:0] ADDRS [NA] = '{16'h1234, 16'hFFFF, 16'h00E1,
                                           16'hABCD, 16'h0001, 16'h5A3C};

    localparam logic [15:0] A_FIX  = 16'h0042;
    localparam logic [7:0]  D_PRE  = 8'h5A;
    localparam logic [7:0]  D_WR   = 8'hC3;
    localparam logic [7:0]  D_HOLD = 8'h3C;

    function automatic logic [16:0] ref_map(input logic [15:0] a, input logic [1:0] m);
        logic [15:0] r;
        case (m)
            2'd0: r = a;
            2'd1: r = (a & 16'hff00) | ((a & 16'h001f) << 3) | ((a >> 5) & 16'h0007);
            2'd2: r = (a & 16'hfe00) | ((a & 16'h003f) << 3) | ((a >> 6) & 16'h0007);
            default: r = (a & 16'hfc00) | ((a & 16'h007f) << 3) | ((a >> 7) & 16'h0007);
        endcase
        return {r, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_beam(input logic [8:0] v, input logic [10:0] h, input logic t,
                            input logic p, input logic il, input logic f);
        vpos = v; hpos = h; tall_mode = t; pal_mode = p; interlace_on = il; odd_field = f;
    endtask

    // Read: strobe for one cycle, result sampled after the next rising edge
    task automatic do_read(output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    // Write: strobe for one cycle, port decision sampled mid-cycle
    task automatic do_write(input logic [7:0] d, output logic we, output logic [7:0] wd);
        @(negedge clk);
        wr_data = d;
        wr_stb  = 1'b1;
        #1;
        we = mem_we;
        wd = mem_wdata;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d, wd;
        logic       v, we;
        string      tag;

        // Reset state (R9)
        repeat (3) @(negedge clk);
        chk("R9 reset rd_valid", rd_valid, 0);
        chk("R9 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle rd_valid", rd_valid, 0);
        chk("R11 idle mem_we", mem_we, 0);

        // Address mapping in every mode (R1, R2, R3)
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < NA; i++) begin
                @(negedge clk);
                map_sel   = 2'(m);
                word_addr = ADDRS[i];
                #1;
                tag = (m == 0) ? "R1 map0" : (m == 1) ? "R2 map1" : "R3 map2/3";
                chk(tag, mem_addr, ref_map(ADDRS[i], 2'(m)));
            end
        end

        // Preload with display forced off (R4)
        map_sel   = 2'd0;
        word_addr = A_FIX;
        hold_byte = D_HOLD;
        blank_force = 1'b1;
        set_beam(9'd100, 11'd300, 1'b0, 1'b0, 1'b0, 1'b0);
        do_write(D_PRE, we, wd);
        chk("R4 forced write we", we, 1);
        do_read(d, v);
        chk("R4 forced read mid-frame", d, D_PRE);
        blank_force = 1'b0;

        // Vector table: beam gating (R5, R6, R7, R8)
        for (int i = 0; i < NV; i++) begin
            set_beam(VECS[i].v, VECS[i].h, VECS[i].tall, VECS[i].pal, VECS[i].il, VECS[i].fld);
            if (i < 8)       tag = "R5 read window";
            else if (i < 16) tag = "R6 end line dot";
            else if (i < 21) tag = "R7 line0 write";
            else             tag = "R8 active write";
            if (VECS[i].kind == 1'b0) begin
                do_read(d, v);
                chk(tag, v, 1);
                chk(tag, d, (VECS[i].expect_k == 2'd1) ? D_PRE : 8'h00);
            end else begin
                do_write(D_WR, we, wd);
                chk(tag, we, (VECS[i].expect_k != 2'd0));
                if (VECS[i].expect_k != 2'd0)
                    chk(tag, wd, (VECS[i].expect_k == 2'd2) ? D_HOLD : D_WR);
            end
        end

        // rd_valid lasts a single cycle (R9)
        set_beam(9'd300, 11'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_read(d, v);
        chk("R9 valid after read", v, 1);
        @(negedge clk);
        chk("R9 valid drops", rd_valid, 0);
        chk("R9 data held", rd_data, D_WR);

        // Dropped write leaves memory unchanged (R8)
        blank_force = 1'b1;
        do_write(8'h77, we, wd);
        blank_force = 1'b0;
        set_beam(9'd100, 11'd20, 1'b0, 1'b0, 1'b0, 1'b0);
        do_write(8'h11, we, wd);
        chk("R8 mid-frame drop we", we, 0);
        blank_force = 1'b1;
        do_read(d, v);
        chk("R8 memory unchanged", d, 8'h77);

        // Simultaneous strobes: write only (R10)
        @(negedge clk);
        wr_data = 8'h99;
        rd_stb = 1'b1;
        wr_stb = 1'b1;
        #1;
        chk("R10 write taken", mem_we, 1);
        @(negedge clk);
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        chk("R10 no read response", rd_valid, 0);
        #1;
        chk("R11 no strobe no write", mem_we, 0);
        do_read(d, v);
        chk("R10 write stored", d, 8'h99);

        finish_run();
    end
endmodule